// File: doc/BRIEF.md
# Dead-Band PWM Generator with Trip Protection

This block generates a pair of pulse-width-modulated outputs from an up-counting time base. The counter runs from zero to a programmable period and then starts again at zero. Each of the two channels compares the counter with its own threshold, so each output stays high for a programmable number of cycles at the start of every period. In complementary mode, only the first channel's waveform is used. Both outputs are derived from it, and a separate programmable gap is placed before each output turns on. This keeps the two switches of a half bridge from conducting together.

A trip input drives both outputs low at once. The trip can be held until software clears it, or it can release by itself at the start of the next period. Software programs the block through a simple synchronous write port. The compare thresholds are double-buffered, so a new value never cuts a pulse short in the middle of a period.

Top module: `edge_pwm`

## Requirements
- R1: The counter counts up by one each cycle from 0. In the cycle after it is at or above the period value (write address 0), it returns to 0. A period lasts period+1 cycles, and the period register takes effect at once.
- R2: In independent mode (mode register at address 5, bit 0 clear), pwmA is high in the cycle after a cycle where the counter is below the active A threshold, and low otherwise. A threshold of 0 gives a constant low. A threshold above the period gives a constant high.
- R3: In independent mode, pwmB is produced the same way from the active B threshold.
- R4: Writes to the A threshold (address 1) and the B threshold (address 2) go to a shadow register. The shadow value becomes the active threshold only when the counter returns to 0.
- R5: In complementary mode (bit 0 set), pwmA rises R+1 cycles after the internal A waveform rises, where R is the rising gap at address 3 (low 8 bits). pwmA falls one cycle after that waveform falls. A pulse shorter than the gap produces no output pulse.
- R6: In complementary mode, pwmB is the inverse of the A waveform. pwmB falls one cycle after the waveform rises and rises F+1 cycles after it falls, where F is the falling gap at address 4. pwmA and pwmB are never high together.
- R7: In latched trip mode (bit 1 set), an asserted trip input sets a trip state that holds until a cycle with tripClr high and tripIn low.
- R8: In cycle-by-cycle trip mode (bit 1 clear), the trip state clears by itself when the counter returns to 0, unless tripIn is still high.
- R9: While the trip state is set, both outputs are low. An asserted tripIn forces both outputs low from the next cycle.
- R10: After reset, all registers are zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 16 | Register write data |
| tripIn | input | 1 | Fault input, active high |
| tripClr | input | 1 | Clears a latched trip |
| pwmA | output | 1 | PWM output A |
| pwmB | output | 1 | PWM output B |

## Verification
Fixed settings with known duty cycles show that the period length and each threshold set the pulse width independently. A threshold write in the middle of a period separates shadowed loading from immediate loading. Short trip pulses in each trip mode separate a latched trip from a cycle-by-cycle trip by when the outputs recover. Random sequences that change the period, thresholds, gaps and mode while trips arrive exercise pulses shorter than the gap and changes of period below the current count.

// File: rtl/edge_pwm_pkg.sv
package edge_pwm_pkg;
  typedef struct packed {
    logic wrap;
    logic tripForce;
  } pwmStrobe_t;

  localparam int unsigned REG_PERIOD = 0;
  localparam int unsigned REG_CMPA   = 1;
  localparam int unsigned REG_CMPB   = 2;
  localparam int unsigned REG_DBRISE = 3;
  localparam int unsigned REG_DBFALL = 4;
  localparam int unsigned REG_MODE   = 5;
endpackage

// File: rtl/edge_pwm_delay.sv
module edge_pwm_delay #(
  parameter int DB_W = 8,
  parameter bit RISE = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sigIn,
  input  logic [DB_W-1:0] delay,
  output logic            sigOut
);
  logic lvl;
  logic core;
  logic [DB_W-1:0] waitCnt;

  generate
    if (RISE) begin : g_rise
      assign lvl    = sigIn;
      assign sigOut = core;
    end else begin : g_fall
      assign lvl    = ~sigIn;
      assign sigOut = ~core;
    end
  endgenerate

  // core follows lvl falling at once, rising only after delay extra cycles
  always_ff @(posedge clk) begin
    if (!rstN) begin
      core    <= 1'b0;
      waitCnt <= '0;
    end else if (!lvl) begin
      core    <= 1'b0;
      waitCnt <= '0;
    end else if (!core) begin
      if (waitCnt == delay) core <= 1'b1;
      else                  waitCnt <= waitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/edge_pwm_ctrl.sv
module edge_pwm_ctrl
  import edge_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] period,
  input  logic             latchMode,
  input  logic             tripIn,
  input  logic             tripClr,
  output logic [CNT_W-1:0] cnt,
  output pwmStrobe_t       strobes
);
  logic [CNT_W-1:0] cntQ;
  logic tripQ;
  logic atEnd;

  assign atEnd = (cntQ >= period);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= '0;
      tripQ <= 1'b0;
    end else begin
      cntQ <= atEnd ? '0 : cntQ + 1'b1;
      if (tripIn)                 tripQ <= 1'b1;
      else if (latchMode)         tripQ <= tripClr ? 1'b0 : tripQ;
      else if (atEnd)             tripQ <= 1'b0;
    end
  end

  assign cnt               = cntQ;
  assign strobes.wrap      = atEnd;
  assign strobes.tripForce = tripQ;
endmodule

// File: rtl/edge_pwm_datapath.sv
module edge_pwm_datapath
  import edge_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DB_W   = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [CNT_W-1:0]  cnt,
  input  pwmStrobe_t        strobes,
  output logic [CNT_W-1:0]  period,
  output logic              latchMode,
  output logic              compMode,
  output logic              pwmA,
  output logic              pwmB
);
  localparam int NCH = 2;

  logic [CNT_W-1:0] periodQ;
  logic [DB_W-1:0]  dbRiseQ, dbFallQ;
  logic [1:0]       modeQ;
  logic [NCH-1:0]   rawOut;
  logic [NCH-1:0]   indQ;
  logic             redA, fedA;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodQ <= '0;
      dbRiseQ <= '0;
      dbFallQ <= '0;
      modeQ   <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_W'(REG_PERIOD)) periodQ <= wrData;
      if (wrAddr == ADDR_W'(REG_DBRISE)) dbRiseQ <= wrData[DB_W-1:0];
      if (wrAddr == ADDR_W'(REG_DBFALL)) dbFallQ <= wrData[DB_W-1:0];
      if (wrAddr == ADDR_W'(REG_MODE))   modeQ   <= wrData[1:0];
    end
  end

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_ch
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_CMPA + ch);
      logic [CNT_W-1:0] shadowQ, activeQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          shadowQ <= '0;
          activeQ <= '0;
          indQ[ch] <= 1'b0;
        end else begin
          if (strobes.wrap)              activeQ <= shadowQ;
          if (wrEn && wrAddr == MY_ADDR) shadowQ <= wrData;
          indQ[ch] <= rawOut[ch];
        end
      end
      assign rawOut[ch] = (cnt < activeQ);
    end
  endgenerate

  edge_pwm_delay #(.DB_W(DB_W), .RISE(1'b1)) uRise (
    .clk(clk), .rstN(rstN), .sigIn(rawOut[0]), .delay(dbRiseQ), .sigOut(redA)
  );
  edge_pwm_delay #(.DB_W(DB_W), .RISE(1'b0)) uFall (
    .clk(clk), .rstN(rstN), .sigIn(rawOut[0]), .delay(dbFallQ), .sigOut(fedA)
  );

  assign period    = periodQ;
  assign compMode  = modeQ[0];
  assign latchMode = modeQ[1];
  assign pwmA = (compMode ? redA  : indQ[0]) & ~strobes.tripForce;
  assign pwmB = (compMode ? ~fedA : indQ[1]) & ~strobes.tripForce;
endmodule

// File: rtl/edge_pwm.sv
module edge_pwm
  import edge_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DB_W   = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              tripIn,
  input  logic              tripClr,
  output logic              pwmA,
  output logic              pwmB
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period;
  logic latchMode, compMode, tripActive;
  pwmStrobe_t strobes;

  edge_pwm_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .period(period), .latchMode(latchMode),
    .tripIn(tripIn), .tripClr(tripClr), .cnt(cnt), .strobes(strobes)
  );

  edge_pwm_datapath #(.CNT_W(CNT_W), .DB_W(DB_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cnt(cnt), .strobes(strobes), .period(period), .latchMode(latchMode),
    .compMode(compMode), .pwmA(pwmA), .pwmB(pwmB)
  );

  assign tripActive = strobes.tripForce;
endmodule

// File: rtl/edge_pwm_checker.sv
module edge_pwm_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period,
  input logic             tripIn,
  input logic             tripClr,
  input logic             latchMode,
  input logic             compMode,
  input logic             tripActive,
  input logic             pwmA,
  input logic             pwmB
);
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cnt >= period) |=> (cnt == '0));

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rstN)
    compMode |-> !(pwmA && pwmB));

  assert_latched_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (latchMode && tripActive && !tripClr) |=> tripActive);

  assert_cbc_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!latchMode && tripActive && !tripIn && cnt >= period) |=> !tripActive);

  assert_trip_force_R9: assert property (@(posedge clk) disable iff (!rstN)
    tripIn |=> (!pwmA && !pwmB));
endmodule

bind edge_pwm edge_pwm_checker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .cnt(cnt), .period(period), .tripIn(tripIn),
  .tripClr(tripClr), .latchMode(latchMode), .compMode(compMode),
  .tripActive(tripActive), .pwmA(pwmA), .pwmB(pwmB)
);

// File: tb/sim_edge_pwm.sv
`timescale 1ns/1ps
module sim_edge_pwm;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic tripIn = 1'b0, tripClr = 1'b0;
  logic pwmA, pwmB;
  int checks = 0, errors = 0;
  bit done = 0;
  string curTag = "";

  always #5 clk = ~clk;

  edge_pwm u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
               .tripIn(tripIn), .tripClr(tripClr), .pwmA(pwmA), .pwmB(pwmB));

  // reference model state, built from the requirements
  logic [15:0] mCnt, mPer, mShA, mShB, mActA, mActB;
  logic [7:0]  mDbR, mDbF, rc, fc;
  logic [1:0]  mMode;
  logic        mTrip, rCore, fCore, indA, indB;

  task automatic modelReset();
    mCnt = 0; mPer = 0; mShA = 0; mShB = 0; mActA = 0; mActB = 0;
    mDbR = 0; mDbF = 0; rc = 0; fc = 0; mMode = 0;
    mTrip = 0; rCore = 0; fCore = 0; indA = 0; indB = 0;
  endtask

  task automatic modelStep(input logic we, input logic [2:0] a, input logic [15:0] d,
                           input logic tin, input logic tclr);
    logic rawA, rawB, wrap;
    rawA = mCnt < mActA;
    rawB = mCnt < mActB;
    wrap = mCnt >= mPer;
    if (tin) mTrip = 1;
    else if (mMode[1]) begin if (tclr) mTrip = 0; end
    else if (wrap) mTrip = 0;
    if (!rawA) begin rCore = 0; rc = 0; end
    else if (!rCore) begin if (rc == mDbR) rCore = 1; else rc = rc + 1; end
    if (rawA) begin fCore = 0; fc = 0; end
    else if (!fCore) begin if (fc == mDbF) fCore = 1; else fc = fc + 1; end
    indA = rawA; indB = rawB;
    mCnt = wrap ? 16'd0 : mCnt + 16'd1;
    if (wrap) begin mActA = mShA; mActB = mShB; end
    if (we) case (a)
      3'd0: mPer = d;
      3'd1: mShA = d;
      3'd2: mShB = d;
      3'd3: mDbR = d[7:0];
      3'd4: mDbF = d[7:0];
      3'd5: mMode = d[1:0];
      default: ;
    endcase
  endtask

  task automatic compare();
    logic eA, eB;
    string tA, tB;
    eA = (mMode[0] ? rCore : indA) & ~mTrip;
    eB = (mMode[0] ? fCore : indB) & ~mTrip;
    if (curTag != "") begin tA = curTag; tB = curTag; end
    else if (mTrip) begin tA = "R9"; tB = "R9"; end
    else if (mMode[0]) begin tA = "R5"; tB = "R6"; end
    else begin tA = "R2"; tB = "R3"; end
    checks += 2;
    if (pwmA !== eA) begin errors++; $display("FAIL %s pwmA actual %b expected %b", tA, pwmA, eA); end
    if (pwmB !== eB) begin errors++; $display("FAIL %s pwmB actual %b expected %b", tB, pwmB, eB); end
  endtask

  // drive one cycle of inputs, advance model, sample at the next falling edge
  task automatic cyc(input logic we, input logic [2:0] a, input logic [15:0] d,
                     input logic tin, input logic tclr);
    wrEn = we; wrAddr = a; wrData = d; tripIn = tin; tripClr = tclr;
    modelStep(we, a, d, tin, tclr);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cyc(1, a, d, 0, 0);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hiA, hiB;
    void'($urandom(32'd4242));
    modelReset();
    repeat (3) @(negedge clk);
    // R10: outputs low in reset and after release with zero registers
    checks += 2;
    if (pwmA !== 1'b0) begin errors++; $display("FAIL R10 pwmA actual %b expected 0", pwmA); end
    if (pwmB !== 1'b0) begin errors++; $display("FAIL R10 pwmB actual %b expected 0", pwmB); end
    rstN = 1'b1;
    curTag = "R10"; idle(5);

    // R1: period 9 with thresholds 3 and 5 -> 3 and 5 high cycles in every 10
    curTag = "R1";
    wr(0, 16'd9); wr(1, 16'd3); wr(2, 16'd5);
    idle(22);
    hiA = 0; hiB = 0;
    for (int i = 0; i < 30; i++) begin
      cyc(0, 0, 0, 0, 0);
      hiA += pwmA; hiB += pwmB;
    end
    checks += 2;
    if (hiA != 9) begin errors++; $display("FAIL R1 A high count actual %0d expected 9", hiA); end
    if (hiB != 15) begin errors++; $display("FAIL R3 B high count actual %0d expected 15", hiB); end

    // R4: threshold change mid-period waits for the wrap
    curTag = "R4";
    idle(4); wr(1, 16'd8); idle(25);

    // R7: latched trip holds until clear
    curTag = "R7";
    wr(5, 16'h2); cyc(0, 0, 0, 1, 0); idle(30);
    cyc(0, 0, 0, 1, 1); idle(3);
    cyc(0, 0, 0, 0, 1); idle(20);

    // R8: cycle-by-cycle trip recovers at next period start
    curTag = "R8";
    wr(5, 16'h0); idle(3); cyc(0, 0, 0, 1, 0); idle(25);

    // R5/R6 directed: complementary with gaps 3 and 2, and a gap longer than the pulse
    curTag = "";
    wr(3, 16'd3); wr(4, 16'd2); wr(5, 16'h1); wr(1, 16'd6); idle(40);
    wr(3, 16'd9); idle(30); wr(3, 16'd0); wr(4, 16'd0); idle(20);
    // R2 edges: threshold 0 and above period
    wr(5, 16'h0); wr(1, 16'd0); wr(2, 16'd20); idle(30);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 4) begin
        logic [2:0] a;
        logic [15:0] d;
        a = 3'($urandom % 6);
        case (a)
          3'd0: d = 16'(3 + $urandom % 28);
          3'd1, 3'd2: d = 16'($urandom % 34);
          3'd3, 3'd4: d = 16'($urandom % 6);
          default: d = 16'($urandom % 4);
        endcase
        cyc(1, a, d, 0, 0);
      end else if (r < 5) cyc(0, 0, 0, 1, 0);
      else if (r < 7) cyc(0, 0, 0, 0, 1);
      else cyc(0, 0, 0, 0, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule